// File: doc/BRIEF.md
# Clock Source and Low-Power State Controller

This block decides which oscillator clocks the processor core and the peripherals, and it runs the low-power states of a small microcontroller. The block runs on one free-running reference clock. Each oscillator is presented to it as a one-cycle tick strobe: `main_tick` for the fast oscillator and `sub_tick` for the slow one. Its outputs are per-cycle enables: the core advances on cycles where `cpu_clk_en` is high, and the peripherals advance where `per_clk_en` is high. A two-bit clock-select register sets the source. Bit 1 chooses the slow source. Bit 0 asks for the fast oscillator to be powered down. A separate sleep register holds the idle request.

Software leaves the slow source in several ordered steps. It writes 10 to power the fast oscillator, waits for warm-up, and then writes 00 to select the fast source. A change of source passes through synchronizer flops that are clocked by each oscillator's own ticks. The old source is let go before the new one is taken, so the core never sees two sources at once. The code keeps running throughout a source change.

The idle state (sleep) stops only the core. The deep state (stop) powers down the fast oscillator and leaves the slow one running. Stop ends on one of a fixed set of wake sources. If the fast oscillator has to restart, the core is held for a programmed number of slow ticks. The block then resumes in the mode it was in before stop.

Top module: `clkpwr_ctrl`

## Requirements
- R1: After reset, and after a reset taken during stop, `mode` is 00 (main active), `main_osc_en` is 1, and `cpu_clk_en` and `per_clk_en` follow `main_tick`.
- R2: A clock-select write (`wr_addr`=0) of 10 moves the core to the slow source. `mode` becomes 01 (sub active), both enables follow `sub_tick`, and `main_osc_en` stays 1.
- R3: A clock-select write of 11 drives `main_osc_en` low, but only once the core runs from the slow source. This holds also when the register was 00 at the time of the write. While `mode` reads 00 in the run state, `main_osc_en` is never 0.
- R4: A clock-select write of 00, made from 10 or from 11, turns the fast oscillator on and returns `mode` to 00, with both enables following `main_tick` again.
- R5: A clock-select write of the reserved value 01 is ignored, and the mode and oscillator state stay as before.
- R6: The two sources are never both active. `cpu_clk_en` is high only in a cycle that carries a tick of the active source.
- R7: A sleep-register write (`wr_addr`=1) with bit 0 set gives `mode` 10 (sleep) and holds `cpu_clk_en` at 0, while `per_clk_en` keeps following the active source. Bit 1 of that write has no effect.
- R8: Any set bit of `irq_pend` during sleep ends sleep on the next clock edge, and the core returns to its previous mode.
- R9: A `stop_req` pulse in the run state gives `mode` 11 (stop), `main_osc_en` 0 and `cpu_clk_en` 0, with `per_clk_en` following `sub_tick`. A `stop_req` during sleep is ignored.
- R10: Stop is left only through a set bit of `stop_wake` or through reset. `irq_pend` has no effect in stop.
- R11: After a wake, if the fast oscillator was on before stop, `mode` stays 11 and `cpu_clk_en` stays 0 for exactly `warm_len` slow ticks. If the fast oscillator was off, no ticks are spent.
- R12: After stop, the block resumes in the clock mode that was selected before stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle strobe per fast oscillator period |
| sub_tick | input | 1 | One-cycle strobe per slow oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the clock-select register, 1 the sleep register |
| wr_data | input | 2 | Write data |
| stop_req | input | 1 | Request to enter stop |
| irq_pend | input | NIRQ | Enabled pending interrupts (sleep wake) |
| stop_wake | input | NWAKE | Stop wake sources: key scan, watch timer, counter pin, serial clock, external interrupt, spare |
| warm_len | input | WARM_W | Warm-up length in slow ticks |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| main_osc_en | output | 1 | Fast oscillator power enable |
| mode | output | 2 | 00 main, 01 sub, 10 sleep, 11 stop |

## Verification
Several properties are checked on every cycle, whatever the stimulus:
- the two source-active flags are exclusive;
- a core enable appears only on a tick of the active source;
- the fast oscillator is powered whenever it is the active source in the run state;
- sleep gates the core and ends on an interrupt;
- stop silences the core and the fast oscillator and ends on a wake source.

Some behaviour can only be shown by the bench's scenarios: the exact warm-up count in slow ticks, the rejection of the reserved code and of the sleep bit 1, the return to the pre-stop mode, and the end-to-end path from each register write to a settled mode.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

  typedef enum logic [1:0] {
    MODE_MAIN  = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_STOP  = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    PS_RUN  = 2'b00,
    PS_STOP = 2'b01,
    PS_WARM = 2'b10
  } pwr_state_e;

  localparam int CKSEL_W = 2;
  localparam logic [CKSEL_W-1:0] CKSEL_RESERVED = 2'b01;

  // a clock-select code is taken unless it is the reserved one
  function automatic logic cksel_accept(input logic [CKSEL_W-1:0] v);
    return v != CKSEL_RESERVED;
  endfunction

  // the fast oscillator may be dropped only when bit 0 asks for it and
  // the slow source already carries the core
  function automatic logic osc_keep(input logic [CKSEL_W-1:0] cksel, input logic on_sub);
    return !(cksel[0] && on_sub);
  endfunction

  function automatic pwr_mode_e mode_encode(input pwr_state_e st, input logic slp,
                                            input logic on_sub);
    if (st != PS_RUN) return MODE_STOP;
    if (slp)          return MODE_SLEEP;
    if (on_sub)       return MODE_SUB;
    return MODE_MAIN;
  endfunction

endpackage

// File: rtl/clkpwr_modereg.sv
module clkpwr_modereg
  import clkpwr_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [CKSEL_W-1:0] wr_data,
  input  logic               run_ok,
  input  logic [NIRQ-1:0]    irq_pend,
  output logic [CKSEL_W-1:0] cksel,
  output logic               sleeping
);

  logic wr_cksel, wr_sleep, irq_any;

  assign wr_cksel = wr_en && run_ok && !wr_addr && cksel_accept(wr_data);
  assign wr_sleep = wr_en && run_ok && wr_addr && wr_data[0];
  assign irq_any  = |irq_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cksel <= '0;
    end else if (wr_cksel) begin
      cksel <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleeping <= 1'b0;
    end else if (sleeping && irq_any) begin
      sleeping <= 1'b0;
    end else if (wr_sleep) begin
      sleeping <= 1'b1;
    end
  end

endmodule

// File: rtl/clkpwr_sync_chain.sv
module clkpwr_sync_chain #(
  parameter int   N    = 2,
  parameter logic INIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         req,
  output logic [N-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= {N{INIT}};
    end else if (tick) begin
      q <= {q[N-2:0], req};
    end
  end

endmodule

// File: rtl/clkpwr_selsync.sv
module clkpwr_selsync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_tick_g,
  input  logic sub_tick,
  input  logic sel_sub,
  output logic act_main,
  output logic act_sub
);

  localparam int NSRC = 2;   // index 0: fast source, index 1: slow source

  logic [NSRC-1:0][SYNC_N-1:0] chain;
  logic [NSRC-1:0]             tick_v;
  logic [NSRC-1:0]             req_v;

  assign tick_v[0] = main_tick_g;
  assign tick_v[1] = sub_tick;

  // a source is requested only after the other chain has fully drained
  assign req_v[0] = !sel_sub && !(|chain[1]);
  assign req_v[1] =  sel_sub && !(|chain[0]);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    clkpwr_sync_chain #(
      .N    (SYNC_N),
      .INIT (1'(g == 0))
    ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_v[g]),
      .req   (req_v[g]),
      .q     (chain[g])
    );
  end

  assign act_main = chain[0][SYNC_N-1];
  assign act_sub  = chain[1][SYNC_N-1];

endmodule

// File: rtl/clkpwr_stopctl.sv
module clkpwr_stopctl
  import clkpwr_pkg::*;
#(
  parameter int NWAKE  = 6,
  parameter int WARM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_take,
  input  logic              osc_on_now,
  input  logic [NWAKE-1:0]  stop_wake,
  input  logic              sub_tick,
  input  logic [WARM_W-1:0] warm_len,
  output pwr_state_e        st
);

  logic              need_warm;
  logic [WARM_W-1:0] cnt;
  logic              wake_any;

  assign wake_any = |stop_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_RUN;
      need_warm <= 1'b0;
      cnt       <= '0;
    end else begin
      case (st)
        PS_RUN: begin
          cnt <= '0;
          if (stop_take) begin
            st        <= PS_STOP;
            need_warm <= osc_on_now;
          end
        end
        PS_STOP: begin
          if (wake_any) st <= need_warm ? PS_WARM : PS_RUN;
        end
        PS_WARM: begin
          if (cnt == warm_len) st  <= PS_RUN;
          else if (sub_tick)   cnt <= cnt + 1'b1;
        end
        default: st <= PS_RUN;
      endcase
    end
  end

endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import clkpwr_pkg::*;
#(
  parameter int NIRQ   = 8,
  parameter int NWAKE  = 6,
  parameter int WARM_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_tick,
  input  logic              sub_tick,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [1:0]        wr_data,
  input  logic              stop_req,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic [NWAKE-1:0]  stop_wake,
  input  logic [WARM_W-1:0] warm_len,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              main_osc_en,
  output logic [1:0]        mode
);

  // named internal events, also observed by the bound checker
  logic [CKSEL_W-1:0] cksel;
  logic               sleeping;
  logic               act_main, act_sub;
  logic               main_tick_g;
  logic               src_tick;
  logic               run_ok;
  logic               stop_take;
  logic               st_run, st_stop, st_warm;
  logic               wake_any, irq_any;
  pwr_state_e         st;

  assign st_run    = (st == PS_RUN);
  assign st_stop   = (st == PS_STOP);
  assign st_warm   = (st == PS_WARM);
  assign run_ok    = st_run && !sleeping;
  assign stop_take = stop_req && run_ok;
  assign wake_any  = |stop_wake;
  assign irq_any   = |irq_pend;

  clkpwr_modereg #(.NIRQ(NIRQ)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .run_ok   (run_ok),
    .irq_pend (irq_pend),
    .cksel    (cksel),
    .sleeping (sleeping)
  );

  clkpwr_stopctl #(.NWAKE(NWAKE), .WARM_W(WARM_W)) u_stop (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_take  (stop_take),
    .osc_on_now (!cksel[0]),
    .stop_wake  (stop_wake),
    .sub_tick   (sub_tick),
    .warm_len   (warm_len),
    .st         (st)
  );

  assign main_osc_en = st_run ? osc_keep(cksel, act_sub) : st_warm;
  assign main_tick_g = main_tick && main_osc_en;

  clkpwr_selsync #(.SYNC_N(SYNC_N)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_tick_g (main_tick_g),
    .sub_tick    (sub_tick),
    .sel_sub     (cksel[1]),
    .act_main    (act_main),
    .act_sub     (act_sub)
  );

  assign src_tick   = (main_tick_g && act_main) || (sub_tick && act_sub);
  assign cpu_clk_en = src_tick && run_ok;
  assign per_clk_en = st_run ? src_tick : sub_tick;
  assign mode       = mode_encode(st, sleeping, act_sub);

endmodule

// File: rtl/clkpwr_chk.sv
module clkpwr_chk (
  input logic clk,
  input logic rst_n,
  input logic act_main,
  input logic act_sub,
  input logic main_tick,
  input logic sub_tick,
  input logic main_osc_en,
  input logic cpu_clk_en,
  input logic sleeping,
  input logic irq_any,
  input logic stop_take,
  input logic st_run,
  input logic st_stop,
  input logic wake_any
);

  assert_src_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_main && act_sub));

  assert_cpu_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> ((main_tick && main_osc_en && act_main) || (sub_tick && act_sub)));

  assert_osc_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && act_main) |-> main_osc_en);

  assert_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !cpu_clk_en);

  assert_sleep_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && irq_any) |=> !sleeping);

  assert_stop_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_take |=> st_stop);

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_stop |-> (!main_osc_en && !cpu_clk_en));

  assert_stop_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stop && wake_any) |=> !st_stop);

endmodule

bind clkpwr_ctrl clkpwr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_main    (act_main),
  .act_sub     (act_sub),
  .main_tick   (main_tick),
  .sub_tick    (sub_tick),
  .main_osc_en (main_osc_en),
  .cpu_clk_en  (cpu_clk_en),
  .sleeping    (sleeping),
  .irq_any     (irq_any),
  .stop_take   (stop_take),
  .st_run      (st_run),
  .st_stop     (st_stop),
  .wake_any    (wake_any)
);

// File: tb/tb_clkpwr_ctrl.sv
`timescale 1ns/1ps
module tb_clkpwr_ctrl;
  import clkpwr_pkg::*;

  localparam int NIRQ = 8, NWAKE = 6, WARM_W = 8, SUBP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic main_tick = 1'b0, sub_tick = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [1:0] wr_data = '0;
  logic stop_req = 1'b0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [NWAKE-1:0] stop_wake = '0;
  logic [WARM_W-1:0] warm_len = '0;
  logic cpu_clk_en, per_clk_en, main_osc_en;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1:0] cm_exp = 2'b00;

  clkpwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stop_req(stop_req),
    .irq_pend(irq_pend), .stop_wake(stop_wake), .warm_len(warm_len),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .main_osc_en(main_osc_en), .mode(mode)
  );

  always #2 clk = ~clk;

  function automatic logic [1:0] exp_mode(input logic [1:0] cm);
    return cm[1] ? 2'b01 : 2'b00;
  endfunction
  function automatic logic exp_osc(input logic [1:0] cm);
    return cm != 2'b11;
  endfunction
  function automatic logic exp_tick(input logic [1:0] cm, input logic mt, input logic st);
    return cm[1] ? st : mt;
  endfunction
  function automatic logic [1:0] next_cm(input logic [1:0] cm, input logic [1:0] d);
    return (d == 2'b01) ? cm : d;
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    main_tick = (cyc % 2 == 0);
    sub_tick  = (cyc % SUBP == 3);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic write_reg(input logic a, input logic [1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic settle(input string req);
    int bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (mode == 2'b00 && !main_osc_en) bad++;
      step();
    end
    chk(bad == 0, req, "osc off while main selected", bad, 0);
  endtask

  task automatic steady(input string req);
    int bad = 0;
    chk(mode == exp_mode(cm_exp), req, "mode", mode, exp_mode(cm_exp));
    chk(main_osc_en == exp_osc(cm_exp), req, "main_osc_en", main_osc_en, exp_osc(cm_exp));
    for (int i = 0; i < 16; i++) begin
      if (cpu_clk_en != exp_tick(cm_exp, main_tick, sub_tick) || per_clk_en != cpu_clk_en) bad++;
      step();
    end
    chk(bad == 0, req, "enable pattern mismatches", bad, 0);
  endtask

  task automatic set_cm(input logic [1:0] d, input string req);
    write_reg(1'b0, d);
    cm_exp = next_cm(cm_exp, d);
    settle(req);
    steady(req);
  endtask

  task automatic do_sleep();
    int bad = 0;
    write_reg(1'b1, 2'b01);
    for (int i = 0; i < 16; i++) begin
      if (mode != 2'b10 || cpu_clk_en ||
          per_clk_en != exp_tick(cm_exp, main_tick, sub_tick)) bad++;
      step();
    end
    chk(bad == 0, "R7", "sleep gating mismatches", bad, 0);
    stop_req = 1'b1; step(); stop_req = 1'b0;
    chk(mode == 2'b10, "R9", "stop_req during sleep", mode, 2);
    irq_pend = NIRQ'($urandom % 255 + 1);
    step();
    irq_pend = '0;
    chk(mode == exp_mode(cm_exp), "R8", "mode after interrupt", mode, exp_mode(cm_exp));
    steady("R8");
  endtask

  task automatic do_stop(input logic [WARM_W-1:0] len);
    int bad = 0, n = 0, guard = 0, expn;
    warm_len = len;
    expn = exp_osc(cm_exp) ? int'(len) : 0;
    stop_req = 1'b1; step(); stop_req = 1'b0;
    chk(mode == 2'b11, "R9", "mode in stop", mode, 3);
    chk(main_osc_en == 1'b0, "R9", "osc in stop", main_osc_en, 0);
    for (int i = 0; i < 12; i++) begin
      if (cpu_clk_en || per_clk_en != sub_tick) bad++;
      step();
    end
    chk(bad == 0, "R9", "stop enables mismatches", bad, 0);
    irq_pend = 8'hFF; step(); step(); irq_pend = '0;
    chk(mode == 2'b11, "R10", "irq must not end stop", mode, 3);
    while (!sub_tick) step();
    stop_wake = NWAKE'(1) << ($urandom % NWAKE);
    step();
    stop_wake = '0;
    bad = 0;
    while (mode == 2'b11 && guard < 400) begin
      if (sub_tick) n++;
      if (cpu_clk_en) bad++;
      guard++;
      step();
    end
    chk(n == expn, "R11", "warm-up slow ticks", n, expn);
    chk(bad == 0, "R11", "core enabled during warm-up", bad, 0);
    settle("R12");
    steady("R12");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(mode == 2'b00, "R1", "mode after reset", mode, 0);
    steady("R1");
    set_cm(2'b10, "R2");
    set_cm(2'b11, "R3");
    set_cm(2'b00, "R4");        // straight from 11
    set_cm(2'b01, "R5");        // reserved code, ignored
    set_cm(2'b11, "R3");        // from 00: oscillator kept until handover
    set_cm(2'b10, "R4");
    set_cm(2'b00, "R4");
    // R7 sleep bit 1 alone has no effect
    write_reg(1'b1, 2'b10);
    chk(mode == 2'b00, "R7", "sleep bit1 ignored", mode, 0);
    do_sleep();
    do_stop(8'd3);
    set_cm(2'b11, "R3");
    do_stop(8'd4);              // oscillator was off: no warm-up
    set_cm(2'b10, "R2");
    do_stop(8'd0);
    // R1 reset taken in stop lands in main active
    stop_req = 1'b1; step(); stop_req = 1'b0;
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    cm_exp = 2'b00;
    chk(mode == 2'b00, "R1", "mode after reset in stop", mode, 0);
    steady("R1");
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 4)
        0: set_cm(2'($urandom % 4), "R5");
        1: do_sleep();
        2: do_stop(WARM_W'($urandom % 6));
        default: steady("R6");
      endcase
    end
    summary();
    $finish;
  end

endmodule